// File: doc/BRIEF.md
# Half-Bridge Fault Guard

This block sits between a serial command register and the gate drivers of three half-bridges. It takes a command word that holds one enable bit for each high-side and low-side switch, plus a few control bits. From these it derives six registered gate enables. Before any switch is driven, the requested state is masked by the protection logic: shoot-through requests, per-switch overcurrent latch-off, supply overvoltage lockout, supply undervoltage hold-off, thermal shutdown and the enable pin.

The faults that need software attention are kept in sticky flags. They stay set until a command word arrives with its reset bit set. Overvoltage masking is the exception: it is not latched. The programmed enables are kept in the register, so the outputs come back by themselves once the overvoltage ends. The overcurrent delay is counted in clock cycles, and the long or short delay is chosen per switch at the moment its timing starts.

Top module: `hbridge_guard`

## Requirements
- R1: A command is captured on a clock edge with `load` high. For bridge k (k = 0..2), bit 2k+1 enables the low switch and bit 2k+2 enables the high switch. The gates show the new command on the next clock edge after capture.
- R2: A captured command that asks for both switches of the same bridge turns both of them off and sets `flag_sta`. High and low of one bridge are never on together.
- R3: A bridge blocked by a shoot-through request stays off for every later command that lacks the reset bit (bit 0). A command with bit 0 set clears the block and `flag_sta`.
- R4: An overcurrent seen on a driven switch for OC_LONG consecutive cycles (bit 13 = 0) or OC_SHORT cycles (bit 13 = 1) sets `flag_oc` on the last of those cycles. The gate of that switch alone turns off one edge later.
- R5: The delay is fixed from bit 13 when overcurrent timing starts. Changing bit 13 while the timer runs has no effect on that run.
- R6: A switch latched off by overcurrent, and `flag_oc`, stay as they are until a command with bit 0 set is captured.
- R7: If the overcurrent goes away before the delay expires, that switch's timer starts again from zero.
- R8: `flag_psf` sets while `ov_in` or `uv_in` is high, whatever bit 15 says. It stays set until a command with bit 0 set is captured with no supply fault present.
- R9: With bit 15 = 1, all gates go off one edge after `ov_in` rises. They return to the programmed state one edge after it falls. With bit 15 = 0, `ov_in` leaves the gates unchanged.
- R10: All gates are off one edge after `uv_in` is seen high. Commands captured during undervoltage still update the register and appear once it ends.
- R11: Any `tw_in` bit sets the sticky `flag_tw` without changing the gates. Only a command with bit 0 set clears it.
- R12: Any `tsd_in` bit turns all gates off one edge later and sets `flag_tsd`. The gates come back only when a command with bit 0 set is captured while no `tsd_in` bit is high.
- R13: During reset, and one edge after `en_pin` is seen low, all gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | 1 | Enable pin; low forces all gates off |
| load | input | 1 | Strobe that captures `cmd_word` |
| cmd_word | input | 16 | Command: reset bit 0, switch enables 1..6, delay select 13, lockout 15 |
| oc_hi | input | 3 | Overcurrent comparator, high switch of each bridge |
| oc_lo | input | 3 | Overcurrent comparator, low switch of each bridge |
| ov_in | input | 1 | Supply overvoltage |
| uv_in | input | 1 | Supply undervoltage |
| tw_in | input | 3 | Thermal warning per bridge |
| tsd_in | input | 3 | Thermal shutdown per bridge |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| flag_sta | output | 1 | Sticky shoot-through flag |
| flag_oc | output | 1 | Sticky overcurrent flag |
| flag_psf | output | 1 | Sticky supply-fail flag |
| flag_tw | output | 1 | Sticky thermal-warning flag |
| flag_tsd | output | 1 | Thermal shutdown latch state |

## Verification
The bench builds the block with three bridges, OC_LONG = 12 and OC_SHORT = 4. With these values both overcurrent delays expire within a few dozen cycles. This lets the bench probe each delay one cycle short of expiry and at expiry. It also changes bit 13 inside a running long delay, at a point where the short delay would already have fired. It interrupts a timer one cycle before expiry to show the count restarts.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  localparam int CMD_W    = 16;
  localparam int RST_BIT  = 0;
  localparam int DSEL_BIT = 13;
  localparam int LOCK_BIT = 15;

  function automatic int lo_bit(input int k);
    return 2 * k + 1;
  endfunction

  function automatic int hi_bit(input int k);
    return 2 * k + 2;
  endfunction
endpackage

// File: rtl/hbg_cmd_reg.sv
module hbg_cmd_reg #(
  parameter int NBR = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [hbg_pkg::CMD_W-1:0] cmd_word,
  output logic [NBR-1:0]           en_lo,
  output logic [NBR-1:0]           en_hi,
  output logic                     dsel,
  output logic                     lock,
  output logic                     clr,
  output logic [NBR-1:0]           sta_blk
);
  import hbg_pkg::*;

  logic unused_cmd;
  assign unused_cmd = ^cmd_word;

  assign clr = load & cmd_word[RST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      dsel <= 1'b0;
      lock <= 1'b0;
    end else if (load) begin
      dsel <= cmd_word[DSEL_BIT];
      lock <= cmd_word[LOCK_BIT];
    end
  end

  for (genvar k = 0; k < NBR; k++) begin : g_br
    localparam int LB = lo_bit(k);
    localparam int HB = hi_bit(k);
    always_ff @(posedge clk) begin
      if (rst) begin
        en_lo[k]   <= 1'b0;
        en_hi[k]   <= 1'b0;
        sta_blk[k] <= 1'b0;
      end else if (load) begin
        en_lo[k]   <= cmd_word[LB];
        en_hi[k]   <= cmd_word[HB];
        sta_blk[k] <= (cmd_word[LB] & cmd_word[HB]) |
                      (sta_blk[k] & ~cmd_word[RST_BIT]);
      end
    end
  end
endmodule

// File: rtl/hbg_oc_timer.sv
module hbg_oc_timer #(
  parameter int OC_LONG  = 200,
  parameter int OC_SHORT = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_in,
  input  logic sw_on,
  input  logic dsel_live,
  input  logic clr,
  output logic latched
);
  localparam int CW = $clog2(OC_LONG + 1);
  localparam logic [CW-1:0] L_END = CW'(OC_LONG - 1);
  localparam logic [CW-1:0] S_END = CW'(OC_SHORT - 1);

  logic [CW-1:0] cnt;
  logic          sel_q;
  logic          sel_eff;
  logic [CW-1:0] end_val;

  // The select is taken live on the first counted cycle, then held.
  assign sel_eff = (cnt == '0) ? dsel_live : sel_q;
  assign end_val = sel_eff ? S_END : L_END;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sel_q   <= 1'b0;
      latched <= 1'b0;
    end else begin
      if (clr) latched <= 1'b0;
      if (oc_in && sw_on && !latched) begin
        if (cnt == '0) sel_q <= dsel_live;
        if (cnt == end_val) begin
          latched <= 1'b1;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/hbg_flags.sv
module hbg_flags #(
  parameter int NBR = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           ov_in,
  input  logic           uv_in,
  input  logic [NBR-1:0] tw_in,
  input  logic [NBR-1:0] tsd_in,
  output logic           psf,
  output logic           tw,
  output logic           tsd_lat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      psf     <= 1'b0;
      tw      <= 1'b0;
      tsd_lat <= 1'b0;
    end else begin
      psf     <= ov_in | uv_in | (psf & ~clr);
      tw      <= (|tw_in) | (tw & ~clr);
      tsd_lat <= (|tsd_in) | (tsd_lat & ~clr);
    end
  end
endmodule

// File: rtl/hbg_gate_drv.sv
module hbg_gate_drv #(
  parameter int NBR = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NBR-1:0] en_lo,
  input  logic [NBR-1:0] en_hi,
  input  logic [NBR-1:0] sta_blk,
  input  logic [NBR-1:0] oc_lat_lo,
  input  logic [NBR-1:0] oc_lat_hi,
  input  logic           tsd_lat,
  input  logic           tsd_any,
  input  logic           en_pin,
  input  logic           uv_in,
  input  logic           ov_in,
  input  logic           lock,
  output logic [NBR-1:0] gate_lo,
  output logic [NBR-1:0] gate_hi
);
  logic glob_ok;
  assign glob_ok = en_pin & ~uv_in & ~(ov_in & lock) & ~tsd_lat & ~tsd_any;

  for (genvar k = 0; k < NBR; k++) begin : g_br
    logic br_ok;
    assign br_ok = glob_ok & ~sta_blk[k];
    always_ff @(posedge clk) begin
      if (rst) begin
        gate_lo[k] <= 1'b0;
        gate_hi[k] <= 1'b0;
      end else begin
        gate_lo[k] <= br_ok & en_lo[k] & ~oc_lat_lo[k];
        gate_hi[k] <= br_ok & en_hi[k] & ~oc_lat_hi[k];
      end
    end
  end
endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard #(
  parameter int NBR      = 3,
  parameter int OC_LONG  = 200,
  parameter int OC_SHORT = 25
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en_pin,
  input  logic                      load,
  input  logic [hbg_pkg::CMD_W-1:0] cmd_word,
  input  logic [NBR-1:0]            oc_hi,
  input  logic [NBR-1:0]            oc_lo,
  input  logic                      ov_in,
  input  logic                      uv_in,
  input  logic [NBR-1:0]            tw_in,
  input  logic [NBR-1:0]            tsd_in,
  output logic [NBR-1:0]            gate_hi,
  output logic [NBR-1:0]            gate_lo,
  output logic                      flag_sta,
  output logic                      flag_oc,
  output logic                      flag_psf,
  output logic                      flag_tw,
  output logic                      flag_tsd
);
  logic [NBR-1:0] en_lo, en_hi, sta_blk, lat_lo, lat_hi;
  logic           dsel, lock, clr;

  hbg_cmd_reg #(.NBR(NBR)) u_cmd (
    .clk(clk), .rst(rst), .load(load), .cmd_word(cmd_word),
    .en_lo(en_lo), .en_hi(en_hi), .dsel(dsel), .lock(lock),
    .clr(clr), .sta_blk(sta_blk)
  );

  for (genvar k = 0; k < NBR; k++) begin : g_oc
    hbg_oc_timer #(.OC_LONG(OC_LONG), .OC_SHORT(OC_SHORT)) u_lo (
      .clk(clk), .rst(rst), .oc_in(oc_lo[k]), .sw_on(gate_lo[k]),
      .dsel_live(dsel), .clr(clr), .latched(lat_lo[k])
    );
    hbg_oc_timer #(.OC_LONG(OC_LONG), .OC_SHORT(OC_SHORT)) u_hi (
      .clk(clk), .rst(rst), .oc_in(oc_hi[k]), .sw_on(gate_hi[k]),
      .dsel_live(dsel), .clr(clr), .latched(lat_hi[k])
    );
  end

  hbg_flags #(.NBR(NBR)) u_flags (
    .clk(clk), .rst(rst), .clr(clr), .ov_in(ov_in), .uv_in(uv_in),
    .tw_in(tw_in), .tsd_in(tsd_in), .psf(flag_psf), .tw(flag_tw),
    .tsd_lat(flag_tsd)
  );

  hbg_gate_drv #(.NBR(NBR)) u_drv (
    .clk(clk), .rst(rst), .en_lo(en_lo), .en_hi(en_hi), .sta_blk(sta_blk),
    .oc_lat_lo(lat_lo), .oc_lat_hi(lat_hi), .tsd_lat(flag_tsd),
    .tsd_any(|tsd_in), .en_pin(en_pin), .uv_in(uv_in), .ov_in(ov_in),
    .lock(lock), .gate_lo(gate_lo), .gate_hi(gate_hi)
  );

  assign flag_sta = |sta_blk;
  assign flag_oc  = |{lat_lo, lat_hi};
endmodule

// File: rtl/hbridge_guard_chk.sv
module hbridge_guard_chk #(
  parameter int NBR = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      en_pin,
  input logic                      load,
  input logic [hbg_pkg::CMD_W-1:0] cmd_word,
  input logic                      uv_in,
  input logic [NBR-1:0]            tsd_in,
  input logic [NBR-1:0]            gate_hi,
  input logic [NBR-1:0]            gate_lo,
  input logic                      flag_oc,
  input logic                      flag_psf,
  input logic                      flag_tw
);
  logic rst_cmd;
  assign rst_cmd = load & cmd_word[hbg_pkg::RST_BIT];

  // R2
  no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == '0);

  // R13
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en_pin) |-> (gate_hi | gate_lo) == '0);

  // R10
  uv_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(uv_in) |-> (gate_hi | gate_lo) == '0);

  // R12
  tsd_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(|tsd_in) |-> (gate_hi | gate_lo) == '0);

  // R8
  psf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flag_psf) && !$past(rst_cmd) |-> flag_psf);

  // R6
  oc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flag_oc) && !$past(rst_cmd) |-> flag_oc);

  // R11
  tw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flag_tw) && !$past(rst_cmd) |-> flag_tw);
endmodule

bind hbridge_guard hbridge_guard_chk #(.NBR(NBR)) u_chk (
  .clk(clk), .rst(rst), .en_pin(en_pin), .load(load), .cmd_word(cmd_word),
  .uv_in(uv_in), .tsd_in(tsd_in), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .flag_oc(flag_oc), .flag_psf(flag_psf), .flag_tw(flag_tw)
);

// File: tb/test_hbridge_guard.sv
module test_hbridge_guard;
  localparam int NBR = 3;
  localparam int LNG = 12;
  localparam int SHT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_pin = 1'b1;
  logic load = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [NBR-1:0] oc_hi = '0, oc_lo = '0, tw_in = '0, tsd_in = '0;
  logic ov_in = 1'b0, uv_in = 1'b0;
  logic [NBR-1:0] gate_hi, gate_lo;
  logic flag_sta, flag_oc, flag_psf, flag_tw, flag_tsd;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  hbridge_guard #(.NBR(NBR), .OC_LONG(LNG), .OC_SHORT(SHT)) i_hbridge_guard (
    .clk(clk), .rst(rst), .en_pin(en_pin), .load(load), .cmd_word(cmd_word),
    .oc_hi(oc_hi), .oc_lo(oc_lo), .ov_in(ov_in), .uv_in(uv_in),
    .tw_in(tw_in), .tsd_in(tsd_in), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .flag_sta(flag_sta), .flag_oc(flag_oc), .flag_psf(flag_psf),
    .flag_tw(flag_tw), .flag_tsd(flag_tsd)
  );

  function automatic logic [5:0] gv(input logic [15:0] w);
    logic [5:0] v;
    for (int k = 0; k < NBR; k++) begin
      v[k]     = w[2*k+1];
      v[3 + k] = w[2*k+2];
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk); cmd_word = w; load = 1'b1;
    @(negedge clk); load = 1'b0;
    @(posedge clk); #1;
  endtask

  function automatic logic [5:0] gates();
    return {gate_hi, gate_lo};
  endfunction

  task automatic t_reset();
    chk("R13 reset gates", 32'(gates()), 0);
    chk("R13 reset flags", 32'({flag_sta, flag_oc, flag_psf, flag_tw, flag_tsd}), 0);
  endtask

  task automatic t_basic();
    send(16'h004C);
    chk("R1 pattern A", 32'(gates()), 32'(gv(16'h004C)));
    send(16'h0022);
    chk("R1 pattern B", 32'(gates()), 32'(gv(16'h0022)));
    en_pin = 1'b0; step();
    chk("R13 enable low", 32'(gates()), 0);
    en_pin = 1'b1; step();
    chk("R13 enable back", 32'(gates()), 32'(gv(16'h0022)));
  endtask

  task automatic t_sta();
    send(16'h001C);
    chk("R2 both off", 32'(gates()), 32'(gv(16'h0004)));
    chk("R2 flag", 32'(flag_sta), 1);
    send(16'h0010);
    chk("R3 still blocked", 32'(gates()), 0);
    send(16'h0011);
    chk("R3 cleared gates", 32'(gates()), 32'(gv(16'h0010)));
    chk("R3 cleared flag", 32'(flag_sta), 0);
  endtask

  task automatic t_oc_long();
    send(16'h0044);
    oc_hi = 3'b001;
    for (int i = 1; i <= LNG + 1; i++) begin
      step();
      if (i == LNG - 1) chk("R4 long early", 32'(flag_oc), 0);
      if (i == LNG) begin
        chk("R4 long flag", 32'(flag_oc), 1);
        chk("R4 gate held", 32'(gates()), 32'(gv(16'h0044)));
      end
    end
    chk("R4 only affected off", 32'(gates()), 32'(gv(16'h0040)));
    oc_hi = '0;
    send(16'h0044);
    chk("R6 no reset stays off", 32'(gates()), 32'(gv(16'h0040)));
    chk("R6 flag held", 32'(flag_oc), 1);
    send(16'h0045);
    chk("R6 reset restores", 32'(gates()), 32'(gv(16'h0044)));
    chk("R6 flag cleared", 32'(flag_oc), 0);
  endtask

  task automatic t_oc_short();
    send(16'h2004);
    oc_hi = 3'b001;
    for (int i = 1; i <= SHT; i++) begin
      step();
      if (i == SHT - 1) chk("R4 short early", 32'(flag_oc), 0);
      if (i == SHT) chk("R4 short flag", 32'(flag_oc), 1);
    end
    oc_hi = '0;
    send(16'h0005);
  endtask

  task automatic t_oc_keep();
    send(16'h0004);
    oc_hi = 3'b001;
    for (int i = 1; i <= LNG; i++) begin
      step();
      if (i == 2) begin cmd_word = 16'h2004; load = 1'b1; end
      if (i == 3) load = 1'b0;
      if (i == LNG - 1) chk("R5 select not reloaded", 32'(flag_oc), 0);
      if (i == LNG) chk("R5 long kept", 32'(flag_oc), 1);
    end
    oc_hi = '0;
    send(16'h0005);
  endtask

  task automatic t_oc_restart();
    send(16'h0004);
    oc_hi = 3'b001;
    for (int i = 1; i <= LNG - 1; i++) step();
    oc_hi = '0; step();
    oc_hi = 3'b001;
    for (int i = 1; i <= LNG; i++) begin
      step();
      if (i == LNG - 1) chk("R7 restarted", 32'(flag_oc), 0);
      if (i == LNG) chk("R7 full delay", 32'(flag_oc), 1);
    end
    oc_hi = '0;
    send(16'h0005);
  endtask

  task automatic t_ov();
    send(16'h8044);
    ov_in = 1'b1; step();
    chk("R9 lockout off", 32'(gates()), 0);
    chk("R8 psf set", 32'(flag_psf), 1);
    ov_in = 1'b0; step();
    chk("R9 restored", 32'(gates()), 32'(gv(16'h0044)));
    chk("R8 psf sticky", 32'(flag_psf), 1);
    send(16'h8045);
    chk("R8 psf cleared", 32'(flag_psf), 0);
    send(16'h0044);
    ov_in = 1'b1; step();
    chk("R9 no lockout", 32'(gates()), 32'(gv(16'h0044)));
    chk("R8 psf without lock", 32'(flag_psf), 1);
    ov_in = 1'b0;
    send(16'h0045);
  endtask

  task automatic t_uv();
    send(16'h0004);
    uv_in = 1'b1; step();
    chk("R10 uv off", 32'(gates()), 0);
    send(16'h0040);
    chk("R10 uv still off", 32'(gates()), 0);
    uv_in = 1'b0; step();
    chk("R10 new command applied", 32'(gates()), 32'(gv(16'h0040)));
    send(16'h0041);
    chk("R8 psf cleared after uv", 32'(flag_psf), 0);
  endtask

  task automatic t_tw();
    tw_in = 3'b010; step();
    chk("R11 tw flag", 32'(flag_tw), 1);
    chk("R11 gates unchanged", 32'(gates()), 32'(gv(16'h0040)));
    tw_in = '0; step();
    chk("R11 tw sticky", 32'(flag_tw), 1);
    send(16'h0041);
    chk("R11 tw cleared", 32'(flag_tw), 0);
  endtask

  task automatic t_tsd();
    tsd_in = 3'b100; step();
    chk("R12 tsd off", 32'(gates()), 0);
    chk("R12 tsd flag", 32'(flag_tsd), 1);
    send(16'h0041);
    chk("R12 reset while hot", 32'(gates()), 0);
    tsd_in = '0; step(); step();
    chk("R12 cooled no reset", 32'(gates()), 0);
    send(16'h0040);
    chk("R12 plain command", 32'(gates()), 0);
    send(16'h0041);
    chk("R12 re-enabled", 32'(gates()), 32'(gv(16'h0040)));
    chk("R12 flag cleared", 32'(flag_tsd), 0);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_basic();
    t_sta();
    t_oc_long();
    t_oc_short();
    t_oc_keep();
    t_oc_restart();
    t_ov();
    t_uv();
    t_tw();
    t_tsd();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule